// File: doc/BRIEF.md
# Elapsed-Time Counter with Triggered Start

This block measures elapsed time with a 12-bit counter that counts up from a value the host loads. Four tick strobes come from outside: 16 Hz, one per second, one per minute and one per hour. A two-bit source field picks which strobe advances the count. When the count rolls over from all ones to zero, a sticky overflow flag is set. If the interrupt enable is on, an active-low interrupt line is pulled low while the flag stays set.

Counting starts in one of two ways. In immediate mode it starts as soon as the host sets the enable bit. In triggered mode, setting the enable bit only arms the counter, and the count starts on the next falling edge of an external start pin. Once the count is running, it ignores the pin and carries on until the host clears enable. It keeps counting while the host interface is deselected.

A read-collision flag tells the host that the count moved while the interface was selected, so a multi-byte read may be torn. The flag clears whenever the interface is deselected. The register interface is a simple synchronous write port and a combinational read port, both with a 2-bit address.

Top module: `lapse_counter`

## Requirements
- R1: After a synchronous reset, every register reads 0x00 and `irq_n` is 1. This covers the enable and start-mode bits.
- R2: The source field is bits [5:4] of address 1. Its code n selects `tick_in[n]`: 0 = 16 Hz, 1 = seconds, 2 = minutes, 3 = hours. Strobes on the other inputs do not change the count.
- R3: While running, each cycle with the selected strobe high adds one to the count. The count is read as address 0 (bits 7:0) plus address 1 bits [3:0] (bits 11:8). While not running, the count holds.
- R4: A step from 0xFFF wraps the count to 0x000 and sets the overflow flag, which is address 1 bit 6.
- R5: `irq_n` is 0 exactly while the overflow flag is 1 and the interrupt enable (address 2 bit 1) is 1.
- R6: The overflow flag stays set until a write to address 1 with bit 6 = 0. Writing 1 to bit 6 leaves the flag as it is.
- R7: With start-mode (address 2 bit 2) = 0, writing enable (address 2 bit 0) from 0 to 1 starts counting at the next selected strobe.
- R8: With start-mode = 1, writing enable to 1 only arms the counter. Strobes are ignored until a high-to-low edge on `start_pin`, and counting then begins.
- R9: Once running, `start_pin` has no effect and counting continues while `host_sel` is 0. Writing enable = 0 stops counting and also cancels an armed start.
- R10: The read-collision flag (address 1 bit 7) is set when the count steps while `host_sel` is 1. It reads 0 on the cycle after `host_sel` is seen low.
- R11: A host write to address 0 or 1 loads that part of the count. A strobe in the same cycle is lost, so the written value is what reads back.
- R12: The read-collision bit is read-only, and host writes to address 1 do not change it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_in | input | 4 | One-cycle strobes; bit n is source code n |
| host_sel | input | 1 | High while the host interface is selected |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write address (0 count low, 1 count high/status, 2 control) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| start_pin | input | 1 | External start; a falling edge starts an armed counter (pre-synchronized) |
| irq_n | output | 1 | Active-low overflow interrupt |

## Verification
The bench checks what happens when a host load and a tick land in the same cycle. A design that applied both would read back the written value plus one. The bench also walks the count over 0xFFF to 0x000 and checks the flag and the interrupt line. A design that flagged at 0xFFF, or cleared the flag on a written 1, would show a wrong status byte or release `irq_n` too early.

Triggered mode is tested with strobes issued before the pin edge, which an eager start would count. The pin is then toggled again after the start and after a disable, to catch a design that restarts, or fails to stop, on later edges. The collision flag is driven with ticks both while selected and while deselected, and a host write to address 1 is issued while the flag is set, to catch a flag that a write can alter.

// File: rtl/lapse_pkg.sv
// Package: shared constants for the elapsed-time counter.
// Assumes an 8-bit host data path and a 2-bit register address.
package lapse_pkg;
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 2;
    localparam int NSRC     = 4;
    localparam int SRC_W    = $clog2(NSRC);

    localparam logic [ADDR_W-1:0] A_CNT_LO = 2'd0;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 2'd1;
    localparam logic [ADDR_W-1:0] A_CTRL   = 2'd2;

    // bit positions in the high/status byte
    localparam int B_SRC_LO  = 4;
    localparam int B_OVF     = 6;
    localparam int B_COLL    = 7;

    // bit positions in the control byte
    localparam int B_EN      = 0;
    localparam int B_IRQEN   = 1;
    localparam int B_TRIG    = 2;

    typedef enum logic [SRC_W-1:0] {
        SRC_16HZ = 2'd0,
        SRC_SEC  = 2'd1,
        SRC_MIN  = 2'd2,
        SRC_HOUR = 2'd3
    } src_e;
endpackage

// File: rtl/lapse_tick_mux.sv
// Module: selects one tick strobe out of NSRC inputs.
// Assumes each strobe is high for a single clock cycle per event.
module lapse_tick_mux #(
    parameter int NSRC  = 4,
    parameter int SEL_W = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]  tick_in,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [NSRC-1:0] gated;

    // each source contributes only when its code is selected
    for (genvar g = 0; g < NSRC; g++) begin : g_src
        assign gated[g] = tick_in[g] && (sel == SEL_W'(g));
    end

    assign tick = |gated;
endmodule

// File: rtl/lapse_start_ctl.sv
// Module: enable, start-mode, arming and run state of the counter.
// Assumes start_pin is already synchronous to clk.
module lapse_start_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr,
    input  logic d_en,
    input  logic d_trig,
    input  logic start_pin,
    output logic en,
    output logic trig_mode,
    output logic run
);
    logic armed;
    logic pin_q;
    logic pin_fall;

    assign pin_fall = pin_q && !start_pin;

    // enable/mode registers, arming on enable write, start on pin fall
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en        <= 1'b0;
            trig_mode <= 1'b0;
            armed     <= 1'b0;
            run       <= 1'b0;
            pin_q     <= 1'b1;
        end else begin
            pin_q <= start_pin;
            if (ctl_wr) begin
                en        <= d_en;
                trig_mode <= d_trig;
                if (!d_en) begin
                    armed <= 1'b0;
                    run   <= 1'b0;
                end else if (!en) begin
                    if (d_trig) armed <= 1'b1;
                    else        run   <= 1'b1;
                end
            end else if (armed && pin_fall) begin
                armed <= 1'b0;
                run   <= 1'b1;
            end
        end
    end

    // R7
    imm_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && d_en && !en && !d_trig) |=> run);
    // R8
    arm_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !pin_fall && !ctl_wr) |=> !run);
    // R9
    run_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !ctl_wr) |=> run);
endmodule

// File: rtl/lapse_count_core.sv
// Module: presettable up counter with sticky overflow and read-collision flag.
// Assumes a host load has priority over a tick in the same cycle.
module lapse_count_core #(
    parameter int CNT_W  = 12,
    parameter int DATA_W = 8,
    localparam int HI_W  = CNT_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              run,
    input  logic              host_sel,
    input  logic              ld_lo,
    input  logic              ld_hi,
    input  logic              ovf_clr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CNT_W-1:0]  count,
    output logic              ovf,
    output logic              collide
);
    logic step;
    logic wrap;

    assign step = run && tick && !ld_lo && !ld_hi;
    assign wrap = step && (&count);

    // count register: host load wins, else step on tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (ld_lo || ld_hi) begin
            if (ld_lo) count[DATA_W-1:0]     <= wr_data;
            if (ld_hi) count[CNT_W-1:DATA_W] <= wr_data[HI_W-1:0];
        end else if (step) begin
            count <= count + 1'b1;
        end
    end

    // overflow flag: set on wrap, cleared only by a written zero
    always_ff @(posedge clk) begin
        if (!rst_n)       ovf <= 1'b0;
        else if (wrap)    ovf <= 1'b1;
        else if (ovf_clr) ovf <= 1'b0;
    end

    // read-collision flag: cleared while deselected, set by a step while selected
    always_ff @(posedge clk) begin
        if (!rst_n)         collide <= 1'b0;
        else if (!host_sel) collide <= 1'b0;
        else if (step)      collide <= 1'b1;
    end

    // R3
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !ld_lo && !ld_hi) |=> count == $past(count) + 1'b1);
    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(run && tick) && !ld_lo && !ld_hi) |=> $stable(count));
    // R4
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !ld_lo && !ld_hi && (&count)) |=> (ovf && count == '0));
    // R6
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf);
    // R10
    sel_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_sel |=> !collide);
    // R11
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_lo |=> count[DATA_W-1:0] == $past(wr_data));
endmodule

// File: rtl/lapse_counter.sv
// Module: top of the elapsed-time counter; register decode and read mux.
// Assumes CNT_W - 8 plus the status bits fill the high byte exactly (CNT_W = 12).
module lapse_counter
    import lapse_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   tick_in,
    input  logic              host_sel,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              start_pin,
    output logic              irq_n
);
    localparam int HI_W = CNT_W - DATA_W;

    logic             wr_lo, wr_hi, wr_ctl;
    logic [SRC_W-1:0] src_q;
    logic             irq_en_q;
    logic             tick;
    logic             en, trig_mode, run;
    logic [CNT_W-1:0] count;
    logic             ovf, collide;

    assign wr_lo  = wr_en && (wr_addr == A_CNT_LO);
    assign wr_hi  = wr_en && (wr_addr == A_CNT_HI);
    assign wr_ctl = wr_en && (wr_addr == A_CTRL);

    // source select and interrupt enable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q    <= '0;
            irq_en_q <= 1'b0;
        end else begin
            if (wr_hi)  src_q    <= wr_data[B_SRC_LO +: SRC_W];
            if (wr_ctl) irq_en_q <= wr_data[B_IRQEN];
        end
    end

    lapse_tick_mux #(.NSRC(NSRC), .SEL_W(SRC_W)) u_mux (
        .tick_in (tick_in),
        .sel     (src_q),
        .tick    (tick)
    );

    lapse_start_ctl u_start (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (wr_ctl),
        .d_en      (wr_data[B_EN]),
        .d_trig    (wr_data[B_TRIG]),
        .start_pin (start_pin),
        .en        (en),
        .trig_mode (trig_mode),
        .run       (run)
    );

    lapse_count_core #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .run      (run),
        .host_sel (host_sel),
        .ld_lo    (wr_lo),
        .ld_hi    (wr_hi),
        .ovf_clr  (wr_hi && !wr_data[B_OVF]),
        .wr_data  (wr_data),
        .count    (count),
        .ovf      (ovf),
        .collide  (collide)
    );

    // read multiplexer
    always_comb begin
        case (rd_addr)
            A_CNT_LO: rd_data = count[DATA_W-1:0];
            A_CNT_HI: rd_data = {collide, ovf, src_q, count[CNT_W-1 -: HI_W]};
            A_CTRL:   rd_data = {5'b0, trig_mode, irq_en_q, en};
            default:  rd_data = '0;
        endcase
    end

    assign irq_n = !(ovf && irq_en_q);
endmodule

// File: tb/lapse_counter_tb_top.sv
`timescale 1ns/100ps
module lapse_counter_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] tick_in = '0;
    logic       host_sel = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       start_pin = 1'b1;
    logic       irq_n;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        int       code;   // 0..3 register address, 4 = irq_n
        logic [7:0] exp;
        string    tag;
    } item_t;
    item_t sb_q[$];

    always #2.5 clk = ~clk;

    lapse_counter dut_i (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .host_sel(host_sel),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .start_pin(start_pin), .irq_n(irq_n)
    );

    // monitor: pops expected items and compares them mid-cycle
    initial begin
        forever begin
            @(negedge clk);
            #0.5;
            if (sb_q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = sb_q.pop_front();
                if (it.code < 4) rd_addr = it.code[1:0];
                #0.5;
                act = (it.code < 4) ? rd_data : {7'b0, irq_n};
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: code %0d actual %02h expected %02h",
                             it.tag, it.code, act, it.exp);
                end
            end
        end
    end

    task automatic expect_val(input int code, input logic [7:0] exp, input string tag);
        item_t it;
        it.code = code; it.exp = exp; it.tag = tag;
        @(negedge clk);
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    task automatic host_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input int idx, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_in[idx] = 1'b1;
            @(negedge clk);
            tick_in[idx] = 1'b0;
        end
    endtask

    task automatic write_with_tick(input logic [1:0] a, input logic [7:0] d, input int idx);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; tick_in[idx] = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick_in[idx] = 1'b0;
    endtask

    task automatic pin_fall_pulse();
        @(negedge clk);
        start_pin = 1'b0;
        @(negedge clk);
        @(negedge clk);
        start_pin = 1'b1;
        @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // driver sequence
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_val(0, 8'h00, "R1 count low after reset");
        expect_val(1, 8'h00, "R1 status after reset");
        expect_val(2, 8'h00, "R1 control after reset");
        expect_val(4, 8'h01, "R1 irq_n after reset");

        // immediate start, 16 Hz source
        host_write(2'd2, 8'h01);
        pulse(0, 3);
        expect_val(0, 8'h03, "R7 R3 immediate start count");

        // other strobes ignored; switch to seconds
        pulse(1, 2);
        expect_val(0, 8'h03, "R2 unselected strobe ignored");
        host_write(2'd1, 8'h10);
        pulse(1, 2);
        pulse(2, 1);
        expect_val(0, 8'h05, "R2 seconds source counts");
        expect_val(1, 8'h10, "R2 source field readback");

        // load vs tick in same cycle
        write_with_tick(2'd0, 8'h40, 1);
        expect_val(0, 8'h40, "R11 load wins over tick");

        // wrap and interrupt
        host_write(2'd2, 8'h03);
        host_write(2'd0, 8'hFE);
        host_write(2'd1, 8'h1F);
        pulse(1, 1);
        expect_val(0, 8'hFF, "R3 count at FFF");
        expect_val(4, 8'h01, "R5 no irq before wrap");
        pulse(1, 1);
        expect_val(0, 8'h00, "R4 wrap to zero");
        expect_val(1, 8'h50, "R4 overflow flag set");
        expect_val(4, 8'h00, "R5 irq asserted");

        // sticky flag
        host_write(2'd1, 8'h50);
        expect_val(1, 8'h50, "R6 writing one keeps flag");
        expect_val(4, 8'h00, "R6 irq stays low");
        host_write(2'd1, 8'h10);
        expect_val(1, 8'h10, "R6 writing zero clears flag");
        expect_val(4, 8'h01, "R5 irq released");

        // collision flag
        @(negedge clk); host_sel = 1'b1;
        pulse(1, 1);
        expect_val(1, 8'h90, "R10 collide set while selected");
        host_write(2'd1, 8'h10);
        expect_val(1, 8'h90, "R12 write does not clear collide");
        @(negedge clk); host_sel = 1'b0;
        expect_val(1, 8'h10, "R10 collide cleared when deselected");
        pulse(1, 1);
        expect_val(0, 8'h02, "R9 counts while deselected");
        expect_val(1, 8'h10, "R10 no collide while deselected");

        // stop, then triggered start
        host_write(2'd2, 8'h00);
        pulse(1, 1);
        expect_val(0, 8'h02, "R9 disable stops count");
        host_write(2'd2, 8'h05);
        pulse(1, 2);
        expect_val(0, 8'h02, "R8 armed does not count");
        pin_fall_pulse();
        pulse(1, 1);
        expect_val(0, 8'h03, "R8 pin fall starts count");
        pin_fall_pulse();
        pulse(1, 1);
        expect_val(0, 8'h04, "R9 pin ignored once running");
        host_write(2'd2, 8'h04);
        pin_fall_pulse();
        pulse(1, 1);
        expect_val(0, 8'h04, "R9 pin does not start when disabled");

        // hours source
        host_write(2'd2, 8'h01);
        host_write(2'd1, 8'h30);
        host_write(2'd0, 8'h00);
        pulse(3, 2);
        pulse(2, 1);
        expect_val(0, 8'h02, "R2 hours source counts");
        expect_val(1, 8'h30, "R2 hours source readback");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule